// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Engine

The engine computes C = A·B for signed 16-bit integer matrices held in an external word-addressed memory with a one-cycle read latency. The result matrix C is written back to the same memory as signed 40-bit words. The output is split into square tiles of `TILE` × `TILE` elements. For each output tile, the engine walks the shared K dimension one tile-wide slice at a time. Each slice goes through three steps: fill two on-chip operand buffers from memory, wait until the last fetched word has landed, then run `TILE` multiply-accumulate steps across the whole output tile at once. When the last K slice is done, the accumulated tile is written out and the engine moves to the next output tile.

The B operand is fetched along memory rows, but each element is placed in its buffer at the mirrored position. Both buffers are therefore indexed by output index first and K index second. Any element that falls outside the matrix is not fetched and is stored as zero. Every tile, partial or not, runs the same schedule.

A host sets the dimensions and the three base addresses and pulses `start`. It then waits for the one-cycle `done` pulse. Each dimension must be at least 1. All three matrices are row-major.

Top module: `tmm_engine`

## Requirements
- R1: Each element C[i][j] equals the sum over k of A[i][k]·B[k][j], computed as 40-bit two's complement. It is written to address c_base + i·N + j.
- R2: Element A[i][k] is read from a_base + i·K + k and element B[k][j] from b_base + k·N + j. Both are 16-bit signed. The read data is taken in the cycle after `mem_rd_en`.
- R3: Reads are issued only for elements inside the matrix bounds; out-of-bounds elements contribute zero. Over one run, the number of reads equals the number of in-bounds elements summed over all (output tile, K slice) pairs.
- R4: Each in-bounds C position is written exactly once and nothing outside C is written. Output tiles go in row-major order of the tile grid, and elements within a tile go in row-major order.
- R5: `done` is high for exactly one cycle, in the cycle after the last write. A `start` pulse while a run is in progress has no effect.
- R6: A memory read and a memory write never happen in the same cycle. No multiply-accumulate step runs while an operand buffer is still being written.
- R7: Dimensions that are not multiples of `TILE` give exact results. The tile grid is ceil(M/T) × ceil(N/T), with ceil(K/T) K slices.
- R8: Number the cycle after the edge that samples `start` as 1. Then `done` is high in cycle tm·tn·(tk·(2T²+T+2)+T²)+1, where tm, tn and tk are the tile counts. This count does not depend on how full the boundary tiles are.
- R9: Sums whose magnitude exceeds 32 bits, such as nine products of −32768 by −32768, are kept exactly in the 40-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| dim_m | input | DIM_W | Rows of A and C |
| dim_n | input | DIM_W | Columns of B and C |
| dim_k | input | DIM_W | Shared dimension |
| a_base | input | ADDR_W | Word address of A[0][0] |
| b_base | input | ADDR_W | Word address of B[0][0] |
| c_base | input | ADDR_W | Word address of C[0][0] |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | EW | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | AW | Write data (accumulator value) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions could meet in one cycle: the last fetched operand word being stored into a buffer, and the first multiply-accumulate step of the K slice. The benches make that final word an in-bounds element that changes the result. In a full tile the last B element feeds every row of the last output column, so a result would show the error if the compute step read the buffer before that word landed. An assertion also checks that buffer writes and compute steps never overlap. The bench separately counts any cycle in which a memory read and a memory write coincide.

// File: rtl/tmm_pkg.sv
// Shared types of the tiled matrix multiply engine.
package tmm_pkg;
    // Sequencer phases: fill buffers, settle, compute, write back, report.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SYNC,
        ST_COMP,
        ST_STORE,
        ST_DONE
    } tmm_state_t;
endpackage

// File: rtl/tmm_tile_buf.sv
// Operand tile buffer: TILE x TILE signed words with one write port.
// The whole tile is visible at the output for the compute array.
// With MIRROR set, a word addressed (row, col) is stored at [col][row],
// so a row-wise fetch of B becomes an output-index-major tile.
// Assumes the writer covers every slot before the tile is consumed.
module tmm_tile_buf #(
    parameter int TILE   = 4,
    parameter int EW     = 16,
    parameter bit MIRROR = 1'b0,
    localparam int IW    = (TILE > 1) ? $clog2(TILE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_row,
    input  logic [IW-1:0]        wr_col,
    input  logic signed [EW-1:0] wr_data,
    output logic signed [EW-1:0] tile [TILE][TILE]
);
    logic [IW-1:0] slot_r;
    logic [IW-1:0] slot_c;

    // Pick the storage coordinates for the chosen orientation.
    generate
        if (MIRROR) begin : g_mirror
            assign slot_r = wr_col;
            assign slot_c = wr_row;
        end else begin : g_direct
            assign slot_r = wr_row;
            assign slot_c = wr_col;
        end
    endgenerate

    // Clear on reset, otherwise store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < TILE; r++) begin
                for (int c = 0; c < TILE; c++) begin
                    tile[r][c] <= '0;
                end
            end
        end else if (wr_en) begin
            tile[slot_r][slot_c] <= wr_data;
        end
    end
endmodule

// File: rtl/tmm_mac_array.sv
// Output tile accumulator: TILE x TILE multiply-accumulate cells.
// In each enabled cycle, cell (i,j) adds a[i][k] * bt[j][k] for the
// current k. A clear pulse zeroes every cell ahead of a new output tile.
// Assumes AW > 2*EW so that products are sign-extended.
module tmm_mac_array #(
    parameter int TILE = 4,
    parameter int EW   = 16,
    parameter int AW   = 40,
    localparam int IW  = (TILE > 1) ? $clog2(TILE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [IW-1:0]        kidx,
    input  logic signed [EW-1:0] a_tile  [TILE][TILE],
    input  logic signed [EW-1:0] bt_tile [TILE][TILE],
    output logic signed [AW-1:0] acc     [TILE][TILE]
);
    generate
        for (genvar i = 0; i < TILE; i++) begin : g_row
            for (genvar j = 0; j < TILE; j++) begin : g_col
                logic [2*EW-1:0] prod;

                // Signed product of the two operands, using the low 2*EW bits.
                always_comb begin
                    prod = {{EW{a_tile[i][kidx][EW-1]}}, a_tile[i][kidx]} *
                           {{EW{bt_tile[j][kidx][EW-1]}}, bt_tile[j][kidx]};
                end

                // Accumulate one K step, or clear for a new tile.
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        acc[i][j] <= '0;
                    end else if (en) begin
                        acc[i][j] <= acc[i][j] + {{(AW-2*EW){prod[2*EW-1]}}, prod};
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tmm_ctrl.sv
// Sequencer of the tiled multiply. It latches dimensions and bases on start.
// For each output tile and each K slice it fetches 2*TILE^2 operand words
// (A first, then B), waits for the last word to land, and then runs TILE
// compute steps. After the last K slice it writes the tile out in
// row-major order. Out-of-bounds words are flagged as zero and never
// fetched. Assumes a read latency of one cycle and dimensions of at least 1.
module tmm_ctrl
    import tmm_pkg::*;
#(
    parameter int TILE   = 4,
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16,
    localparam int IW    = (TILE > 1) ? $clog2(TILE) : 1,
    localparam int CW    = $clog2(2 * TILE * TILE),
    localparam int GW    = DIM_W + IW + 1,
    localparam int DP1   = DIM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  dim_m,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic [DIM_W-1:0]  dim_k,
    input  logic [ADDR_W-1:0] a_base,
    input  logic [ADDR_W-1:0] b_base,
    input  logic [ADDR_W-1:0] c_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic              fill_a,
    output logic              fill_b,
    output logic [IW-1:0]     fill_row,
    output logic [IW-1:0]     fill_col,
    output logic              fill_zero,
    output logic              mac_clr,
    output logic              mac_en,
    output logic [IW-1:0]     mac_k,
    output logic [IW-1:0]     out_r,
    output logic [IW-1:0]     out_c,
    output logic              done
);
    localparam logic [CW-1:0] T_C    = CW'(TILE);
    localparam logic [CW-1:0] TT_C   = CW'(TILE * TILE);
    localparam logic [CW-1:0] LOAD_L = CW'(2 * TILE * TILE - 1);
    localparam logic [CW-1:0] COMP_L = CW'(TILE - 1);
    localparam logic [CW-1:0] STOR_L = CW'(TILE * TILE - 1);

    tmm_state_t        state;
    logic [DIM_W-1:0]  m_q, n_q, k_q, tiles_m, tiles_n, tiles_k, tm, tn, kt;
    logic [ADDR_W-1:0] a_q, b_q, c_q;
    logic [CW-1:0]     idx;
    logic              pend_q, pend_b_q, pend_zero_q;
    logic [IW-1:0]     pend_r_q, pend_c_q;

    logic              is_b, a_in, b_in, s_in, last_k, last_n, last_m;
    logic [CW-1:0]     sub_idx;
    logic [IW-1:0]     ld_r, ld_c;
    logic [GW-1:0]     row_g, colk_g, rowk_g, colj_g;
    logic [ADDR_W-1:0] a_addr, b_addr, s_addr;

    // Tile count of one dimension: ceiling of dim / TILE.
    function automatic logic [DIM_W-1:0] tile_count(input logic [DIM_W-1:0] d);
        logic [DIM_W:0] s;
        s = {1'b0, d} + DP1'(TILE - 1);
        return DIM_W'(s / DP1'(TILE));
    endfunction

    // Decode the counter into tile coordinates, global indices and addresses.
    always_comb begin
        is_b    = (idx >= TT_C);
        sub_idx = is_b ? (idx - TT_C) : idx;
        ld_r    = IW'(sub_idx / T_C);
        ld_c    = IW'(sub_idx % T_C);
        row_g   = GW'(tm) * GW'(TILE) + GW'(ld_r);
        colk_g  = GW'(kt) * GW'(TILE) + GW'(ld_c);
        rowk_g  = GW'(kt) * GW'(TILE) + GW'(ld_r);
        colj_g  = GW'(tn) * GW'(TILE) + GW'(ld_c);
        a_in    = (row_g < GW'(m_q)) && (colk_g < GW'(k_q));
        b_in    = (rowk_g < GW'(k_q)) && (colj_g < GW'(n_q));
        s_in    = (row_g < GW'(m_q)) && (colj_g < GW'(n_q));
        a_addr  = a_q + ADDR_W'(row_g) * ADDR_W'(k_q) + ADDR_W'(colk_g);
        b_addr  = b_q + ADDR_W'(rowk_g) * ADDR_W'(n_q) + ADDR_W'(colj_g);
        s_addr  = c_q + ADDR_W'(row_g) * ADDR_W'(n_q) + ADDR_W'(colj_g);
        last_k  = (kt == tiles_k - DIM_W'(1));
        last_n  = (tn == tiles_n - DIM_W'(1));
        last_m  = (tm == tiles_m - DIM_W'(1));
    end

    // Drive memory, buffer and array controls from the phase.
    always_comb begin
        mem_rd_en   = (state == ST_LOAD) && (is_b ? b_in : a_in);
        mem_rd_addr = is_b ? b_addr : a_addr;
        mem_wr_en   = (state == ST_STORE) && s_in;
        mem_wr_addr = s_addr;
        fill_a      = pend_q && !pend_b_q;
        fill_b      = pend_q && pend_b_q;
        fill_row    = pend_r_q;
        fill_col    = pend_c_q;
        fill_zero   = pend_zero_q;
        mac_en      = (state == ST_COMP);
        mac_k       = IW'(idx);
        out_r       = ld_r;
        out_c       = ld_c;
        done        = (state == ST_DONE);
        mac_clr     = ((state == ST_IDLE) && start) ||
                      ((state == ST_STORE) && (idx == STOR_L) && !(last_n && last_m));
    end

    // Delay each fetch by the memory latency so it meets its returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_b_q    <= 1'b0;
            pend_zero_q <= 1'b0;
            pend_r_q    <= '0;
            pend_c_q    <= '0;
        end else begin
            pend_q      <= (state == ST_LOAD);
            pend_b_q    <= is_b;
            pend_zero_q <= !(is_b ? b_in : a_in);
            pend_r_q    <= ld_r;
            pend_c_q    <= ld_c;
        end
    end

    // Phase sequencing and the tile counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx <= '0;
            {tm, tn, kt} <= '0;
            {m_q, n_q, k_q, tiles_m, tiles_n, tiles_k} <= '0;
            {a_q, b_q, c_q} <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    m_q <= dim_m;  n_q <= dim_n;  k_q <= dim_k;
                    tiles_m <= tile_count(dim_m);
                    tiles_n <= tile_count(dim_n);
                    tiles_k <= tile_count(dim_k);
                    a_q <= a_base; b_q <= b_base; c_q <= c_base;
                    {tm, tn, kt} <= '0;
                    idx   <= '0;
                    state <= ST_LOAD;
                end
                ST_LOAD: begin
                    idx <= (idx == LOAD_L) ? '0 : idx + CW'(1);
                    if (idx == LOAD_L) state <= ST_SYNC;
                end
                ST_SYNC: if (!pend_q) state <= ST_COMP;
                ST_COMP: begin
                    idx <= (idx == COMP_L) ? '0 : idx + CW'(1);
                    if (idx == COMP_L) begin
                        kt    <= last_k ? '0 : kt + DIM_W'(1);
                        state <= last_k ? ST_STORE : ST_LOAD;
                    end
                end
                ST_STORE: begin
                    idx <= (idx == STOR_L) ? '0 : idx + CW'(1);
                    if (idx == STOR_L) begin
                        tn <= last_n ? '0 : tn + DIM_W'(1);
                        if (last_n) tm <= last_m ? '0 : tm + DIM_W'(1);
                        state <= (last_n && last_m) ? ST_DONE : ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tmm_engine.sv
// Top of the tiled matrix multiply engine. It connects the sequencer,
// the row-major A buffer, the mirrored B buffer and the accumulator array.
// Fetched words, or zeros for out-of-bounds slots, go into the buffers.
// The write data is the accumulator cell selected by the store position.
module tmm_engine #(
    parameter int TILE   = 4,
    parameter int EW     = 16,
    parameter int AW     = 40,
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16,
    localparam int IW    = (TILE > 1) ? $clog2(TILE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  dim_m,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic [DIM_W-1:0]  dim_k,
    input  logic [ADDR_W-1:0] a_base,
    input  logic [ADDR_W-1:0] b_base,
    input  logic [ADDR_W-1:0] c_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [EW-1:0]     mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [AW-1:0]     mem_wr_data,
    output logic              done
);
    logic                 fill_a, fill_b, fill_zero, mac_clr, mac_en;
    logic [IW-1:0]        fill_row, fill_col, mac_k, out_r, out_c;
    logic signed [EW-1:0] fill_data;
    logic signed [EW-1:0] a_tile  [TILE][TILE];
    logic signed [EW-1:0] bt_tile [TILE][TILE];
    logic signed [AW-1:0] acc     [TILE][TILE];

    // Replace padded slots with zero instead of memory data.
    always_comb fill_data = fill_zero ? '0 : $signed(mem_rd_data);

    // Select the accumulator cell being written back.
    always_comb mem_wr_data = acc[out_r][out_c];

    tmm_ctrl #(.TILE(TILE), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
        .a_base(a_base), .b_base(b_base), .c_base(c_base),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .fill_a(fill_a), .fill_b(fill_b), .fill_row(fill_row), .fill_col(fill_col),
        .fill_zero(fill_zero), .mac_clr(mac_clr), .mac_en(mac_en), .mac_k(mac_k),
        .out_r(out_r), .out_c(out_c), .done(done)
    );

    tmm_tile_buf #(.TILE(TILE), .EW(EW), .MIRROR(1'b0)) buf_a_i (
        .clk(clk), .rst_n(rst_n), .wr_en(fill_a), .wr_row(fill_row),
        .wr_col(fill_col), .wr_data(fill_data), .tile(a_tile)
    );

    tmm_tile_buf #(.TILE(TILE), .EW(EW), .MIRROR(1'b1)) buf_b_i (
        .clk(clk), .rst_n(rst_n), .wr_en(fill_b), .wr_row(fill_row),
        .wr_col(fill_col), .wr_data(fill_data), .tile(bt_tile)
    );

    tmm_mac_array #(.TILE(TILE), .EW(EW), .AW(AW)) mac_i (
        .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en), .kidx(mac_k),
        .a_tile(a_tile), .bt_tile(bt_tile), .acc(acc)
    );
endmodule

// File: rtl/tmm_checker.sv
// Protocol checker of the engine, attached by bind. It assumes that the
// dimension and base inputs stay constant while a run is in progress.
module tmm_checker #(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              done,
    input logic              mac_en,
    input logic              buf_wr,
    input logic [DIM_W-1:0]  dim_m,
    input logic [DIM_W-1:0]  dim_n,
    input logic [DIM_W-1:0]  dim_k,
    input logic [ADDR_W-1:0] a_base,
    input logic [ADDR_W-1:0] b_base,
    input logic [ADDR_W-1:0] c_base
);
    logic rd_ok, wr_ok;

    // Work out whether each access address lies inside its matrix region.
    always_comb begin
        longint ra, wa;
        ra = longint'(mem_rd_addr);
        wa = longint'(mem_wr_addr);
        rd_ok = (ra >= longint'(a_base) &&
                 ra < longint'(a_base) + longint'(dim_m) * longint'(dim_k)) ||
                (ra >= longint'(b_base) &&
                 ra < longint'(b_base) + longint'(dim_k) * longint'(dim_n));
        wr_ok = (wa >= longint'(c_base) &&
                 wa < longint'(c_base) + longint'(dim_m) * longint'(dim_n));
    end

    assert_rd_in_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> rd_ok);
    assert_wr_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> wr_ok);
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_no_rd_wr_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    assert_compute_after_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_en |-> !buf_wr);
    assert_done_no_traffic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_rd_en || mem_wr_en));
endmodule

bind tmm_engine tmm_checker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .done(done), .mac_en(mac_en), .buf_wr(fill_a | fill_b),
    .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
    .a_base(a_base), .b_base(b_base), .c_base(c_base)
);

// File: tb/tmm_engine_tb_top.sv
// Scoreboard bench: each case pushes the expected writes into a queue, and
// a monitor pops and compares them as the engine writes results.
module tmm_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T  = 4;
    localparam int BA = 0;
    localparam int BB = 1024;
    localparam int BC = 2048;

    typedef struct {
        logic [15:0] addr;
        longint      data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  dim_m = 8'd1, dim_n = 8'd1, dim_k = 8'd1;
    logic [15:0] a_base = 16'(BA), b_base = 16'(BB), c_base = 16'(BC);
    logic        mem_rd_en, mem_wr_en, done;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [15:0] mem_rd_data = '0;
    logic [39:0] mem_wr_data;

    logic [15:0] mem [0:4095];
    exp_t        exp_q [$];
    int          n_checks = 0, n_err = 0, rd_cnt = 0, clash_cnt = 0;
    string       data_tag = "R1";

    tmm_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
        .a_base(a_base), .b_base(b_base), .c_base(c_base),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory model with a read latency of one cycle.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: count reads and clashes, and compare every write with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) rd_cnt++;
            if (mem_rd_en && mem_wr_en) clash_cnt++;
            if (mem_wr_en) begin
                if (exp_q.size() == 0) begin
                    check("R4", "unexpected write address", longint'(mem_wr_addr), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R4", "write address", longint'(mem_wr_addr), longint'(e.addr));
                    check(data_tag, "write data", longint'($signed(mem_wr_data)), e.data);
                end
            end
        end
    end

    function automatic longint a_val(int i, int k, int seed);
        if (seed < 0) return -32768;
        return longint'(((i * 13 + k * 7 + seed * 5) % 41) - 20);
    endfunction

    function automatic longint b_val(int k, int j, int seed);
        if (seed < 0) return (j % 2 == 0) ? -32768 : 32767;
        return longint'(((k * 11 + j * 3 + seed * 9) % 37) - 18);
    endfunction

    // Driver: load memory, push the expected writes, run, and check totals.
    task automatic run_case(input int m, input int n, input int k, input int seed,
                            input string tag, input bit poke);
        int tm, tn, tk, exp_rd, exp_cyc, cyc;
        data_tag = tag;
        for (int x = 0; x < 4096; x++) mem[x] = 16'h1357;
        for (int i = 0; i < m; i++)
            for (int kk = 0; kk < k; kk++) mem[BA + i * k + kk] = 16'(a_val(i, kk, seed));
        for (int kk = 0; kk < k; kk++)
            for (int j = 0; j < n; j++) mem[BB + kk * n + j] = 16'(b_val(kk, j, seed));
        tm = (m + T - 1) / T;  tn = (n + T - 1) / T;  tk = (k + T - 1) / T;
        exp_rd = 0;
        for (int ti = 0; ti < tm; ti++)
            for (int tj = 0; tj < tn; tj++) begin
                for (int tkk = 0; tkk < tk; tkk++)
                    for (int r = 0; r < T; r++)
                        for (int c = 0; c < T; c++) begin
                            if (ti * T + r < m && tkk * T + c < k) exp_rd++;
                            if (tkk * T + r < k && tj * T + c < n) exp_rd++;
                        end
                for (int r = 0; r < T; r++)
                    for (int c = 0; c < T; c++) begin
                        int gi, gj;
                        longint s;
                        gi = ti * T + r;  gj = tj * T + c;
                        if (gi < m && gj < n) begin
                            s = 0;
                            for (int kk = 0; kk < k; kk++) s += a_val(gi, kk, seed) * b_val(kk, gj, seed);
                            exp_q.push_back('{addr: 16'(BC + gi * n + gj), data: s});
                        end
                    end
            end
        exp_cyc = tm * tn * (tk * (2 * T * T + T + 2) + T * T) + 1;
        rd_cnt = 0;
        clash_cnt = 0;
        @(negedge clk);
        dim_m = 8'(m);  dim_n = 8'(n);  dim_k = 8'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (done !== 1'b1 && cyc < 20000) begin
            start = (poke && cyc == 30);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check("R8", "cycles to done", longint'(cyc), longint'(exp_cyc));
        check("R3", "read count", longint'(rd_cnt), longint'(exp_rd));
        check("R4", "writes left unseen", longint'(exp_q.size()), 0);
        check("R6", "read/write clash cycles", longint'(clash_cnt), 0);
        @(negedge clk);
        check("R5", "done after pulse", longint'(done), 0);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            check("R5", "idle read request", longint'(mem_rd_en), 0);
        end
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R5", "done in reset", longint'(done), 0);
        check("R6", "read in reset", longint'(mem_rd_en), 0);
        check("R4", "write in reset", longint'(mem_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "done after reset", longint'(done), 0);
        run_case(4, 4, 4, 1, "R1", 1'b0);
        run_case(5, 6, 7, 2, "R7", 1'b0);
        run_case(3, 2, 9, -1, "R9", 1'b1);
        run_case(1, 1, 1, 3, "R2", 1'b0);
        run_case(8, 8, 8, 4, "R1", 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule